// File: doc/BRIEF.md
# Stream Identifier Span Match Filter

This block decides, for each hardware event counter, whether an incoming event should be counted. Every event arrives with a valid strobe, a 16-bit event code and a stream identifier. Each counter holds two configuration words, both supplied as input ports:

- a 32-bit event-type word, which carries the code that counter accepts and a span flag;
- a match pattern as wide as the stream identifier.

The block compares the identifier against the pattern and produces a registered, one-cycle increment pulse per counter. Counting, interrupts and register access stay outside the block.

Two comparison modes exist:

- **Exact mode.** Every implemented identifier bit must equal the pattern.
- **Span mode.** The pattern carries its own wildcard width. Write t for the number of consecutive ones at the bottom of the pattern (the trailing run of ones). Bit t of the pattern is then zero. Identifier bits t down to 0 are ignored, and every bit above t must match. A pattern of all ones has no terminating zero, so span mode with that pattern accepts every identifier.

A mode input chooses between two ways of applying the filters. In per-counter operation each counter applies its own filter. In global operation counter 0's span flag and pattern serve every counter, while each counter still matches its own event code.

Top module: `sid_span_filter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `inc_o` is all zeros.
- R2: With `ev_valid_i` low, no bit of `inc_o` is set in the following cycle, whatever the code, identifier and configuration.
- R3: Span flag clear (exact mode): a counter fires only when the event identifier equals its pattern in every bit. For example, pattern 0x1234 accepts 0x1234 and rejects 0x1235.
- R4: Span flag set: identifier bits 0 through t are ignored, where t is the length of the trailing run of ones in the pattern. For example, pattern 0x42 accepts 0x42 and 0x43 and rejects 0x44.
- R5: Span flag set with a pattern of all ones (0xFFFF_FFFF): every identifier matches.
- R6: The event-type word holds the accepted code in bits 15:0 and the span flag in bit 29; its other bits have no effect. A counter fires only when the event code equals its own code.
- R7: A counter whose code is 0xFFFF never fires, even when an event with code 0xFFFF arrives.
- R8: With `global_mode_i` high, every counter uses counter 0's span flag and pattern and ignores its own. Each counter keeps its own event code.
- R9: With `global_mode_i` low, each counter applies its own span flag and pattern, independently of the other counters.
- R10: A qualifying strobe sets the counter's `inc_o` bit in the cycle after the strobe, and only in that cycle. Strobes on consecutive cycles give pulses on consecutive cycles.
- R11: A longer trailing run widens the wildcard. Pattern 0x107 (three trailing ones) in span mode accepts 0x100 through 0x10F and rejects 0x110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| global_mode_i | input | 1 | 1: all counters use counter 0's filter; 0: each counter uses its own |
| evt_type_i | input | NUM_CTR*32 | One event-type word per counter, counter 0 in the lowest 32 bits; bits 15:0 hold the code, bit 29 holds the span flag |
| match_pat_i | input | NUM_CTR*SID_W | One match pattern per counter, counter 0 in the lowest bits |
| ev_valid_i | input | 1 | Event strobe |
| ev_code_i | input | 16 | Event code |
| ev_sid_i | input | SID_W | Stream identifier of the event |
| inc_o | output | NUM_CTR | Registered increment pulse for each counter |

## Verification
The bench builds the block with NUM_CTR = 4 and SID_W = 32. Four counters are enough to program exact, short-span, full-wildcard and long-span filters side by side, so a single strobe checks all of them at once. The full 32-bit identifier makes the all-ones pattern reachable, which is the case where the wildcard covers the whole identifier. In global mode, counters 1 to 3 are given their own patterns that differ from counter 0's, so the bench can show that those patterns have no effect.

// File: rtl/sidf_pkg.sv
package sidf_pkg;

    // Layout of one event-type word
    localparam int TYPE_W   = 32;
    localparam int CODE_W   = 16;
    localparam int SPAN_POS = 29;

    // Number of bits of the event-type word that carry no function
    localparam int SPARE_W  = TYPE_W - CODE_W - 1;

    // Code value that must never qualify
    localparam logic [CODE_W-1:0] CODE_NONE = '1;

endpackage

// File: rtl/sidf_span_match.sv
module sidf_span_match #(
    parameter int SID_W = 32
) (
    input  logic             span_i,
    input  logic [SID_W-1:0] pat_i,
    input  logic [SID_W-1:0] sid_i,
    output logic             hit_o
);

    localparam logic [SID_W-1:0] ONE = {{(SID_W-1){1'b0}}, 1'b1};

    logic [SID_W-1:0] pat_inc;
    logic [SID_W-1:0] wild_m;
    logic [SID_W-1:0] care_m;

    always_comb begin
        // Adding one to the pattern clears its trailing ones and sets the zero above them.
        // Pattern XOR (pattern + 1) therefore marks exactly the bits that span mode ignores.
        // For an all-ones pattern the carry drops out of the top, so every bit is marked.
        pat_inc = pat_i + ONE;
        wild_m  = pat_i ^ pat_inc;
        care_m  = span_i ? ~wild_m : '1;
        hit_o   = ((sid_i ^ pat_i) & care_m) == '0;
    end

endmodule

// File: rtl/sidf_ctr_qual.sv
module sidf_ctr_qual
    import sidf_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ev_valid_i,
    input  logic [CODE_W-1:0] ev_code_i,
    input  logic [CODE_W-1:0] cfg_code_i,
    input  logic              sid_hit_i,
    output logic              inc_o
);

    logic code_ok;
    logic qualify;

    always_comb begin
        code_ok = (ev_code_i == cfg_code_i) && (cfg_code_i != CODE_NONE);
        qualify = ev_valid_i && code_ok && sid_hit_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            inc_o <= 1'b0;
        end else begin
            inc_o <= qualify;
        end
    end

    AST_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inc_o |-> $past(ev_valid_i)); // R2

    AST_CODE_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inc_o |-> ($past(ev_code_i) == $past(cfg_code_i))); // R6

    AST_NONE_CODE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inc_o |-> ($past(cfg_code_i) != CODE_NONE)); // R7

    AST_PULSE_FOLLOWS_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inc_o |-> $past(sid_hit_i)); // R10

endmodule

// File: rtl/sid_span_filter.sv
module sid_span_filter
    import sidf_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int SID_W   = 32
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      global_mode_i,
    input  logic [NUM_CTR*TYPE_W-1:0] evt_type_i,
    input  logic [NUM_CTR*SID_W-1:0]  match_pat_i,
    input  logic                      ev_valid_i,
    input  logic [CODE_W-1:0]         ev_code_i,
    input  logic [SID_W-1:0]          ev_sid_i,
    output logic [NUM_CTR-1:0]        inc_o
);

    logic [CODE_W-1:0]        code_v [NUM_CTR];
    logic [SID_W-1:0]         pat_v  [NUM_CTR];
    logic [NUM_CTR-1:0]       span_v;
    logic [NUM_CTR-1:0]       own_hit;
    logic [NUM_CTR-1:0]       used_hit;
    logic [NUM_CTR*SPARE_W-1:0] unused_spare_bits;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        // Split the event-type word into its fields
        assign code_v[g] = evt_type_i[g*TYPE_W +: CODE_W];
        assign span_v[g] = evt_type_i[g*TYPE_W + SPAN_POS];
        assign pat_v[g]  = match_pat_i[g*SID_W +: SID_W];
        assign unused_spare_bits[g*SPARE_W +: SPARE_W] =
            {evt_type_i[g*TYPE_W + SPAN_POS + 1 +: TYPE_W - SPAN_POS - 1],
             evt_type_i[g*TYPE_W + CODE_W +: SPAN_POS - CODE_W]};

        sidf_span_match #(
            .SID_W (SID_W)
        ) u_match (
            .span_i (span_v[g]),
            .pat_i  (pat_v[g]),
            .sid_i  (ev_sid_i),
            .hit_o  (own_hit[g])
        );

        if (g == 0) begin : g_lead
            // Counter 0 always applies its own filter
            assign used_hit[g] = own_hit[0];
        end else begin : g_follow
            // Other counters take counter 0's result in global mode
            assign used_hit[g] = global_mode_i ? own_hit[0] : own_hit[g];

            AST_GLOBAL_EXACT_CTR0: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (inc_o[g] && $past(global_mode_i) && !$past(span_v[0]))
                |-> ($past(ev_sid_i) == $past(pat_v[0]))); // R8
        end

        sidf_ctr_qual u_qual (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .ev_valid_i (ev_valid_i),
            .ev_code_i  (ev_code_i),
            .cfg_code_i (code_v[g]),
            .sid_hit_i  (used_hit[g]),
            .inc_o      (inc_o[g])
        );

        AST_EXACT_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (inc_o[g] && !$past(global_mode_i) && !$past(span_v[g]))
            |-> ($past(ev_sid_i) == $past(pat_v[g]))); // R3

        AST_ALL_ONES_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ev_valid_i && !global_mode_i && span_v[g] && (pat_v[g] == '1)
             && (ev_code_i == code_v[g]) && (code_v[g] != CODE_NONE))
            |=> inc_o[g]); // R5
    end

endmodule

// File: tb/sid_span_filter_tb.sv
module sid_span_filter_tb_top;

    localparam int NC = 4;
    localparam int SW = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             gmode = 1'b0;
    logic [NC*32-1:0] evt_type = '0;
    logic [NC*SW-1:0] pats = '0;
    logic             ev_valid = 1'b0;
    logic [15:0]      ev_code = '0;
    logic [SW-1:0]    ev_sid = '0;
    logic [NC-1:0]    inc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sid_span_filter #(.NUM_CTR(NC), .SID_W(SW)) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .global_mode_i (gmode),
        .evt_type_i    (evt_type),
        .match_pat_i   (pats),
        .ev_valid_i    (ev_valid),
        .ev_code_i     (ev_code),
        .ev_sid_i      (ev_sid),
        .inc_o         (inc)
    );

    task automatic chk(input string req, input logic [NC-1:0] act, input logic [NC-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic set_ctr(input int idx, input logic [15:0] code, input logic span,
                           input logic [31:0] pat, input logic [12:0] spare);
        evt_type[idx*32 +: 32] = {2'b00, span, spare, code};
        pats[idx*SW +: SW]     = pat;
    endtask

    // One strobe, check the pulse in the next cycle and its absence in the one after
    task automatic send(input logic [15:0] code, input logic [31:0] sid,
                        input logic [NC-1:0] exp, input string req);
        ev_valid = 1'b1;
        ev_code  = code;
        ev_sid   = sid;
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        chk(req, inc, exp);
        @(posedge clk);
        @(negedge clk);
        chk("R10 single pulse", inc, '0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 during reset", inc, '0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 after release", inc, '0);
    endtask

    task automatic t_no_strobe();
        gmode = 1'b0;
        set_ctr(0, 16'h0001, 1'b1, 32'hFFFF_FFFF, 13'h0);
        ev_valid = 1'b0;
        ev_code  = 16'h0001;
        ev_sid   = 32'h1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 no strobe", inc, '0);
    endtask

    task automatic t_per_counter();
        gmode = 1'b0;
        set_ctr(0, 16'h0001, 1'b0, 32'h0000_1234, 13'h0);
        set_ctr(1, 16'h0001, 1'b1, 32'h0000_0042, 13'h0);
        set_ctr(2, 16'h0001, 1'b1, 32'hFFFF_FFFF, 13'h0);
        set_ctr(3, 16'h0002, 1'b1, 32'h0000_0107, 13'h1ABC);
        send(16'h0001, 32'h0000_1234, 4'b0101, "R3 R9 exact hit");
        send(16'h0001, 32'h0000_1235, 4'b0100, "R3 exact miss");
        send(16'h0001, 32'h8000_1234, 4'b0100, "R3 top bit differs");
        send(16'h0001, 32'h0000_0042, 4'b0110, "R4 span 0x42");
        send(16'h0001, 32'h0000_0043, 4'b0110, "R4 span 0x43");
        send(16'h0001, 32'h0000_0044, 4'b0100, "R4 span rejects 0x44");
        send(16'h0001, 32'hDEAD_BEEF, 4'b0100, "R5 all ones any sid");
        send(16'h0001, 32'h0000_0000, 4'b0100, "R5 all ones zero sid");
        send(16'h0002, 32'h0000_010A, 4'b1000, "R11 R6 wide span inside");
        send(16'h0002, 32'h0000_0100, 4'b1000, "R11 wide span low edge");
        send(16'h0002, 32'h0000_010F, 4'b1000, "R11 wide span high edge");
        send(16'h0002, 32'h0000_0110, 4'b0000, "R11 wide span outside");
        send(16'h0003, 32'h0000_1234, 4'b0000, "R6 code mismatch");
    endtask

    task automatic t_none_code();
        gmode = 1'b0;
        set_ctr(1, 16'hFFFF, 1'b1, 32'hFFFF_FFFF, 13'h0);
        send(16'hFFFF, 32'h0000_0042, 4'b0000, "R7 code 0xFFFF never fires");
    endtask

    task automatic t_global();
        gmode = 1'b1;
        set_ctr(0, 16'h0001, 1'b0, 32'h0000_0055, 13'h0);
        set_ctr(1, 16'h0002, 1'b1, 32'hFFFF_FFFF, 13'h0);
        set_ctr(2, 16'h0001, 1'b1, 32'h0000_0000, 13'h0);
        set_ctr(3, 16'h0001, 1'b0, 32'h0000_0099, 13'h0);
        send(16'h0001, 32'h0000_0055, 4'b1101, "R8 global shared hit");
        send(16'h0001, 32'h0000_0099, 4'b0000, "R8 own pattern ignored");
        send(16'h0002, 32'h0000_0055, 4'b0010, "R8 own code kept");
        send(16'h0002, 32'h0000_0056, 4'b0000, "R8 own wildcard ignored");
        set_ctr(0, 16'h0001, 1'b1, 32'h0000_0042, 13'h0);
        send(16'h0001, 32'h0000_0043, 4'b1101, "R8 global span");
        gmode = 1'b0;
        send(16'h0001, 32'h0000_0043, 4'b0001, "R9 back to own filters");
    endtask

    task automatic t_back_to_back();
        gmode = 1'b0;
        set_ctr(0, 16'h0001, 1'b0, 32'h0000_0010, 13'h0);
        set_ctr(1, 16'h0001, 1'b0, 32'h0000_0020, 13'h0);
        set_ctr(2, 16'h0005, 1'b0, 32'h0000_0000, 13'h0);
        set_ctr(3, 16'h0005, 1'b0, 32'h0000_0000, 13'h0);
        ev_valid = 1'b1;
        ev_code  = 16'h0001;
        ev_sid   = 32'h10;
        @(posedge clk);
        @(negedge clk);
        ev_sid = 32'h20;
        chk("R10 first of pair", inc, 4'b0001);
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        chk("R10 second of pair", inc, 4'b0010);
        @(posedge clk);
        @(negedge clk);
        chk("R10 idle after pair", inc, 4'b0000);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_no_strobe();
        t_per_counter();
        t_none_code();
        t_global();
        t_back_to_back();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule